// File: doc/BRIEF.md
# Streaming request status register

This block holds the 16-bit status word that sits between a console-side audio and data streaming unit and a host microcontroller. Hardware events raise request flags: a new audio track was asked for, the console wants data from a new stream offset, or the console wrote the play and repeat controls. The host polls the whole word. It acknowledges or changes bits with a single update that carries a set mask and a clear mask.

Two further bits show which half of each ring buffer is being consumed, so the host can refill the idle half. The block owns both read pointers. The audio playback pointer walks a 2 KB buffer and can be rewound to zero. The data read pointer is a 16-bit counter that the host can load with a 16-bit value, and the 16 KB data buffer is indexed by its low bits.

The control handshake is a two-state machine. In `CTL_IDLE` the change bit reads 0. The transition *arm* (a control write, or a host update that sets bit 0) moves it to `CTL_PENDING`, where the change bit reads 1. The transition *rearm* (another control write) keeps it in `CTL_PENDING`. The transition *ack* (a host update that clears bit 0 without setting it, with no control write in the same cycle) returns it to `CTL_IDLE`.

Top module: `stream_req_status`

## Requirements
- R1: While reset is asserted and after it is released, `status`, `audio_ptr` and `data_ptr` are all zero.
- R2: A `track_req` pulse sets bit 5, and the bit stays set until a host update clears it. If a host clear of bit 5 lands in the same cycle as `track_req`, the bit ends up set.
- R3: A `seek_req` pulse sets bit 4, and the bit stays set until a host update clears it. If a host clear of bit 4 lands in the same cycle as `seek_req`, the bit ends up set.
- R4: A `ctrl_wr` pulse sets bit 0, loads bit 1 from `ctrl_play` and loads bit 2 from `ctrl_repeat`. A host update that clears bit 0 returns bit 0 to zero.
- R5: A host update changes only bits 0, 1, 2, 4 and 5. Each of these bits becomes `(old & ~host_clr) | host_set`, so where both masks hit the same bit, the set wins.
- R6: Bits 3, 6 to 12 and 15 always read 0. Host updates have no effect on bits 13 and 14.
- R7: Each `audio_step` cycle advances `audio_ptr` by one, and the pointer wraps from 2047 to 0. Bit 14 equals the most significant bit of `audio_ptr`, which is 1 when the pointer is in the upper 1 KB half.
- R8: Each `data_step` cycle advances the 16-bit `data_ptr` by one, and the pointer wraps from 0xFFFF to 0. `data_load` loads `data_load_val`. Bit 13 equals bit 13 of `data_ptr`, which is 1 when the pointer is in the upper 8 KB half of the 16 KB buffer.
- R9: `audio_rewind` takes priority over `audio_step` in the same cycle, and `data_load` takes priority over `data_step` in the same cycle.
- R10: When `ctrl_wr` coincides with a host update, bit 0 ends up set, and bits 1 and 2 take the `ctrl_play` and `ctrl_repeat` values whatever the host masks say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| track_req | input | 1 | Hardware pulse: new audio track requested |
| seek_req | input | 1 | Hardware pulse: data at a new offset requested |
| ctrl_wr | input | 1 | Hardware pulse: play/repeat controls written |
| ctrl_play | input | 1 | Play (1) or pause (0) value, taken on `ctrl_wr` |
| ctrl_repeat | input | 1 | Repeat value, taken on `ctrl_wr` |
| host_upd | input | 1 | Host update strobe |
| host_set | input | 16 | Bits to set on a host update |
| host_clr | input | 16 | Bits to clear on a host update |
| audio_step | input | 1 | Advance the audio playback pointer |
| audio_rewind | input | 1 | Reset the audio playback pointer to 0 |
| data_step | input | 1 | Advance the data read pointer |
| data_load | input | 1 | Load the data read pointer |
| data_load_val | input | 16 | Value for `data_load` |
| status | output | 16 | Status word polled by the host |
| audio_ptr | output | 11 | Audio playback pointer |
| data_ptr | output | 16 | Data read pointer |

## Verification
Every flag, control bit and pointer result is registered. It becomes visible exactly one rising edge after the inputs that cause it are sampled. The half-buffer bits come straight from the pointer registers, so they change in the same cycle as the pointer. The bench drives every input on a falling edge, lets one rising edge pass, and compares outputs on the following falling edge. Multi-cycle stepping runs count whole cycles before the pointer is checked, which places the half-boundary and wrap checks in the exact cycle the expected value is due.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int ST_W      = 16;
    localparam int BIT_CHG   = 0;
    localparam int BIT_PLAY  = 1;
    localparam int BIT_RPT   = 2;
    localparam int BIT_DSEEK = 4;
    localparam int BIT_TRACK = 5;
    localparam int BIT_DHALF = 13;
    localparam int BIT_AHALF = 14;

    localparam logic [ST_W-1:0] FLAG_MASK   = 16'h0030;
    localparam logic [ST_W-1:0] LIVE_MASK   = 16'h6037;
    localparam logic [ST_W-1:0] UNUSED_MASK = ~LIVE_MASK;

    typedef enum logic [0:0] {
        CTL_IDLE    = 1'b0,
        CTL_PENDING = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/ssr_ring_ptr.sv
module ssr_ring_ptr #(
    parameter int PTR_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             zero,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_nxt;

    always_comb begin
        ptr_nxt = ptr;
        if (zero) begin
            ptr_nxt = '0;
        end else if (load) begin
            ptr_nxt = load_val;
        end else if (step) begin
            ptr_nxt = ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_nxt;
        end
    end
endmodule

// File: rtl/ssr_flag_word.sv
module ssr_flag_word
    import ssr_pkg::*;
#(
    parameter logic [ST_W-1:0] RW_MASK = FLAG_MASK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_upd,
    input  logic [ST_W-1:0] host_set,
    input  logic [ST_W-1:0] host_clr,
    input  logic [ST_W-1:0] hw_set,
    output logic [ST_W-1:0] flags
);
    logic [ST_W-1:0] host_view;
    logic [ST_W-1:0] flags_nxt;

    always_comb begin
        host_view = host_upd ? ((flags & ~host_clr) | host_set) : flags;
        // hardware events are merged last so they beat a host clear
        flags_nxt = (host_view | hw_set) & RW_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= flags_nxt;
        end
    end
endmodule

// File: rtl/ssr_ctl_fsm.sv
module ssr_ctl_fsm
    import ssr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       ctrl_play,
    input  logic       ctrl_repeat,
    input  logic       host_upd,
    input  logic [2:0] host_set,
    input  logic [2:0] host_clr,
    output logic [2:0] ctl_bits
);
    ctl_state_t state_q;
    ctl_state_t state_nxt;
    logic       play_q;
    logic       rpt_q;
    logic       host_arm;
    logic       host_ack;

    always_comb begin
        host_arm = host_upd && host_set[BIT_CHG];
        host_ack = host_upd && host_clr[BIT_CHG] && !host_set[BIT_CHG];
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            CTL_IDLE: begin
                if (ctrl_wr || host_arm) begin
                    state_nxt = CTL_PENDING;
                end
            end
            CTL_PENDING: begin
                if (ctrl_wr) begin
                    state_nxt = CTL_PENDING;
                end else if (host_ack) begin
                    state_nxt = CTL_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_q <= 1'b0;
            rpt_q  <= 1'b0;
        end else if (ctrl_wr) begin
            play_q <= ctrl_play;
            rpt_q  <= ctrl_repeat;
        end else if (host_upd) begin
            play_q <= (play_q & ~host_clr[BIT_PLAY]) | host_set[BIT_PLAY];
            rpt_q  <= (rpt_q & ~host_clr[BIT_RPT]) | host_set[BIT_RPT];
        end
    end

    always_comb begin
        ctl_bits           = '0;
        ctl_bits[BIT_CHG]  = (state_q == CTL_PENDING);
        ctl_bits[BIT_PLAY] = play_q;
        ctl_bits[BIT_RPT]  = rpt_q;
    end
endmodule

// File: rtl/stream_req_status.sv
module stream_req_status
    import ssr_pkg::*;
#(
    parameter int AUD_BYTES = 2048,
    parameter int DAT_BYTES = 16384,
    parameter int DPTR_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         track_req,
    input  logic                         seek_req,
    input  logic                         ctrl_wr,
    input  logic                         ctrl_play,
    input  logic                         ctrl_repeat,
    input  logic                         host_upd,
    input  logic [15:0]                  host_set,
    input  logic [15:0]                  host_clr,
    input  logic                         audio_step,
    input  logic                         audio_rewind,
    input  logic                         data_step,
    input  logic                         data_load,
    input  logic [DPTR_W-1:0]            data_load_val,
    output logic [15:0]                  status,
    output logic [$clog2(AUD_BYTES)-1:0] audio_ptr,
    output logic [DPTR_W-1:0]            data_ptr
);
    localparam int AUD_AW = $clog2(AUD_BYTES);
    localparam int DAT_AW = $clog2(DAT_BYTES);

    logic [ST_W-1:0] hw_word;
    logic [ST_W-1:0] flag_word;
    logic [ST_W-1:0] ctl_word;
    logic [ST_W-1:0] half_word;
    logic [2:0]      ctl_bits;

    always_comb begin
        hw_word            = '0;
        hw_word[BIT_TRACK] = track_req;
        hw_word[BIT_DSEEK] = seek_req;
    end

    ssr_flag_word #(
        .RW_MASK(FLAG_MASK)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_upd(host_upd),
        .host_set(host_set),
        .host_clr(host_clr),
        .hw_set  (hw_word),
        .flags   (flag_word)
    );

    ssr_ctl_fsm u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_play  (ctrl_play),
        .ctrl_repeat(ctrl_repeat),
        .host_upd   (host_upd),
        .host_set   (host_set[2:0]),
        .host_clr   (host_clr[2:0]),
        .ctl_bits   (ctl_bits)
    );

    ssr_ring_ptr #(
        .PTR_W(AUD_AW)
    ) u_aptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (audio_step),
        .zero    (audio_rewind),
        .load    (1'b0),
        .load_val({AUD_AW{1'b0}}),
        .ptr     (audio_ptr)
    );

    ssr_ring_ptr #(
        .PTR_W(DPTR_W)
    ) u_dptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (data_step),
        .zero    (1'b0),
        .load    (data_load),
        .load_val(data_load_val),
        .ptr     (data_ptr)
    );

    always_comb begin
        ctl_word             = '0;
        ctl_word[2:0]        = ctl_bits;
        half_word            = '0;
        half_word[BIT_AHALF] = audio_ptr[AUD_AW-1];
        half_word[BIT_DHALF] = data_ptr[DAT_AW-1];
        status               = flag_word | ctl_word | half_word;
    end
endmodule

// File: rtl/stream_req_status_chk.sv
module stream_req_status_chk
    import ssr_pkg::*;
#(
    parameter int AUD_BYTES = 2048,
    parameter int DPTR_W    = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         track_req,
    input logic                         seek_req,
    input logic                         ctrl_wr,
    input logic                         ctrl_play,
    input logic                         ctrl_repeat,
    input logic                         audio_step,
    input logic                         audio_rewind,
    input logic                         data_step,
    input logic                         data_load,
    input logic [DPTR_W-1:0]            data_load_val,
    input logic [15:0]                  status,
    input logic [$clog2(AUD_BYTES)-1:0] audio_ptr,
    input logic [DPTR_W-1:0]            data_ptr
);
    localparam int AUD_AW = $clog2(AUD_BYTES);

    p_track_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        track_req |=> status[BIT_TRACK]);

    p_seek_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seek_req |=> status[BIT_DSEEK]);

    // R4 and R10: control write wins over any host mask in the same cycle
    p_ctrl_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (status[BIT_CHG] && status[BIT_PLAY] == $past(ctrl_play)
                     && status[BIT_RPT] == $past(ctrl_repeat)));

    p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status & UNUSED_MASK) == 16'h0000);

    p_audio_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (audio_step && !audio_rewind && audio_ptr == {AUD_AW{1'b1}})
        |=> audio_ptr == '0);

    p_data_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !data_load) |=> data_ptr == $past(data_ptr) + DPTR_W'(1));

    p_rewind_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        audio_rewind |=> audio_ptr == '0);

    p_load_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_load |=> data_ptr == $past(data_load_val));
endmodule

bind stream_req_status stream_req_status_chk #(
    .AUD_BYTES(AUD_BYTES),
    .DPTR_W   (DPTR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .track_req    (track_req),
    .seek_req     (seek_req),
    .ctrl_wr      (ctrl_wr),
    .ctrl_play    (ctrl_play),
    .ctrl_repeat  (ctrl_repeat),
    .audio_step   (audio_step),
    .audio_rewind (audio_rewind),
    .data_step    (data_step),
    .data_load    (data_load),
    .data_load_val(data_load_val),
    .status       (status),
    .audio_ptr    (audio_ptr),
    .data_ptr     (data_ptr)
);

// File: tb/stream_req_status_tb.sv
`timescale 1ns/1ps
module stream_req_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        track_req = 1'b0;
    logic        seek_req = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic        ctrl_play = 1'b0;
    logic        ctrl_repeat = 1'b0;
    logic        host_upd = 1'b0;
    logic [15:0] host_set = '0;
    logic [15:0] host_clr = '0;
    logic        audio_step = 1'b0;
    logic        audio_rewind = 1'b0;
    logic        data_step = 1'b0;
    logic        data_load = 1'b0;
    logic [15:0] data_load_val = '0;
    logic [15:0] status;
    logic [10:0] audio_ptr;
    logic [15:0] data_ptr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stream_req_status u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .track_req    (track_req),
        .seek_req     (seek_req),
        .ctrl_wr      (ctrl_wr),
        .ctrl_play    (ctrl_play),
        .ctrl_repeat  (ctrl_repeat),
        .host_upd     (host_upd),
        .host_set     (host_set),
        .host_clr     (host_clr),
        .audio_step   (audio_step),
        .audio_rewind (audio_rewind),
        .data_step    (data_step),
        .data_load    (data_load),
        .data_load_val(data_load_val),
        .status       (status),
        .audio_ptr    (audio_ptr),
        .data_ptr     (data_ptr)
    );

    // vector: req[57:54] trk sk cw pl rp hu [53:48] set[47:32] clr[31:16] exp[15:0]
    localparam int NV = 14;
    localparam logic [57:0] VEC [0:NV-1] = '{
        {4'd2,  6'b100000, 16'h0000, 16'h0000, 16'h0020}, // R2 track flag set
        {4'd2,  6'b000001, 16'h0000, 16'h0020, 16'h0000}, // R2 host clears it
        {4'd3,  6'b010000, 16'h0000, 16'h0000, 16'h0010}, // R3 seek flag set
        {4'd2,  6'b100001, 16'h0000, 16'h0020, 16'h0030}, // R2 hardware beats clear
        {4'd5,  6'b000001, 16'h0000, 16'h0030, 16'h0000}, // R5 clear both flags
        {4'd4,  6'b001100, 16'h0000, 16'h0000, 16'h0003}, // R4 control write play
        {4'd4,  6'b000001, 16'h0004, 16'h0001, 16'h0006}, // R4 ack plus set repeat
        {4'd10, 6'b001011, 16'h0002, 16'h0001, 16'h0005}, // R10 control beats host
        {4'd4,  6'b000001, 16'h0000, 16'h0005, 16'h0000}, // R4 ack and clear repeat
        {4'd6,  6'b000001, 16'hE008, 16'h0000, 16'h0000}, // R6 read-only bits hold
        {4'd5,  6'b000001, 16'h0030, 16'h0030, 16'h0030}, // R5 set wins over clear
        {4'd5,  6'b000001, 16'h0000, 16'hFFFF, 16'h0000}, // R5 clear everything
        {4'd5,  6'b000001, 16'h0001, 16'h0000, 16'h0001}, // R5 host arms change bit
        {4'd4,  6'b000001, 16'h0000, 16'h0001, 16'h0000}  // R4 host ack
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulses_off();
        track_req = 1'b0; seek_req = 1'b0; ctrl_wr = 1'b0;
        host_upd = 1'b0; host_set = '0; host_clr = '0;
        audio_step = 1'b0; audio_rewind = 1'b0;
        data_step = 1'b0; data_load = 1'b0;
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
        pulses_off();
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status in reset", status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after reset", status, 0);
        check("R1 audio_ptr after reset", audio_ptr, 0);
        check("R1 data_ptr after reset", data_ptr, 0);

        for (int i = 0; i < NV; i++) begin
            track_req   = VEC[i][53];
            seek_req    = VEC[i][52];
            ctrl_wr     = VEC[i][51];
            ctrl_play   = VEC[i][50];
            ctrl_repeat = VEC[i][49];
            host_upd    = VEC[i][48];
            host_set    = VEC[i][47:32];
            host_clr    = VEC[i][31:16];
            run_cycles(1);
            check($sformatf("R%0d vector %0d", VEC[i][57:54], i), status, VEC[i][15:0]);
        end

        // R7 audio pointer crosses into upper half
        audio_step = 1'b1;
        run_cycles(1024);
        check("R7 audio_ptr at half", audio_ptr, 1024);
        check("R7 upper-half bit", status, 16'h4000);
        // R6 host cannot clear the half bit
        host_upd = 1'b1; host_clr = 16'h6000;
        run_cycles(1);
        check("R6 half bit ignores host", status, 16'h4000);
        audio_step = 1'b1;
        run_cycles(1023);
        check("R7 audio_ptr at top", audio_ptr, 2047);
        audio_step = 1'b1;
        run_cycles(1);
        check("R7 audio wrap", audio_ptr, 0);
        check("R7 half bit after wrap", status, 0);
        // R9 rewind beats step
        audio_step = 1'b1;
        run_cycles(5);
        check("R7 audio_ptr after 5", audio_ptr, 5);
        audio_step = 1'b1; audio_rewind = 1'b1;
        run_cycles(1);
        check("R9 rewind priority", audio_ptr, 0);

        // R8 data pointer
        data_load = 1'b1; data_load_val = 16'hFFFF;
        run_cycles(1);
        check("R8 data load", data_ptr, 16'hFFFF);
        check("R8 data upper half", status, 16'h2000);
        data_step = 1'b1;
        run_cycles(1);
        check("R8 data wrap", data_ptr, 0);
        check("R8 data lower half", status, 0);
        data_load = 1'b1; data_step = 1'b1; data_load_val = 16'h2000;
        run_cycles(1);
        check("R9 load priority", data_ptr, 16'h2000);
        data_step = 1'b1;
        run_cycles(1);
        check("R8 data step", data_ptr, 16'h2001);
        check("R8 half bit13", status, 16'h2000);

        // R1 reset mid-run
        track_req = 1'b1;
        run_cycles(1);
        check("R2 flag before reset", status, 16'h2020);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 status cleared by reset", status, 0);
        check("R1 data_ptr cleared by reset", data_ptr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule